// File: doc/BRIEF.md
# Graphics write-per-bit mask unit

This block holds the special-function state of a two-bank graphics memory model. It also forms the word that the storage array keeps on each write data beat. It has two 32-bit special registers, a bit mask and a color, which load from the data bus through a mode-set command issued with the special-function pin high. One address-select bit picks the mask and the other picks the color. Each bank has its own write-per-bit enable. An activate command latches that enable from the special-function pin, so an activate with the pin low leaves the bank with masking off.

On every write beat the block merges the new data with the old word read from the array. A byte lane whose byte-mask bit is set keeps its old byte. In the other lanes, when write-per-bit is enabled for the addressed bank, each bit whose mask bit is 1 takes the new value and each bit whose mask bit is 0 keeps its old value. When write-per-bit is off, those lanes take the new data unchanged. The merge is combinational, so single writes, every beat of a burst and block writes all use it with no added latency. If the special-function pin stays low on every command, the block acts as plain memory.

Top module: `wpb_mask_unit`

## Requirements
- R1: An active-low reset clears both per-bank enables, sets the mask register to all ones and clears the color register.
- R2: A mode-set command (cmd 3) with sf_i high and addr_sel_i[0] high loads the mask register from dq_i at that clock edge. A mode-set command with sf_i low leaves the mask unchanged.
- R3: A mode-set command with sf_i high and addr_sel_i[1] high loads the color register from dq_i.
- R4: When both addr_sel_i bits are high on a special mode-set command, the mask and color registers both load from the same dq_i value.
- R5: An activate command (cmd 1) sets wpb_o[bank_i] to the value of sf_i and leaves the other bank's enable unchanged.
- R6: On a write (cmd 2) to a bank whose write-per-bit is enabled, each unblocked bit equals the new bit where the mask bit is 1 and the old bit where it is 0.
- R7: On a write to a bank whose write-per-bit is disabled, every unblocked lane equals dq_i, whatever the mask holds.
- R8: On a write, byte lane b (bits 8b+7..8b) equals old_i whenever bm_i[b] is 1, with write-per-bit on or off.
- R9: A command is accepted on the clock right after a mask load, and a write on that clock already uses the new mask.
- R10: wr_valid_o is high exactly while cmd_i is the write code. Codes 0 and 4 to 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command: 0 idle, 1 activate, 2 write, 3 mode set |
| sf_i | input | 1 | Special-function pin |
| addr_sel_i | input | 2 | Address select bits: [0] selects the mask, [1] selects the color |
| bank_i | input | 1 | Bank select |
| dq_i | input | 32 | Data bus (new write data or register load value) |
| bm_i | input | 4 | Byte-lane block mask, 1 = keep the old byte |
| old_i | input | 32 | Word currently stored at the write address |
| wr_valid_o | output | 1 | A write beat is present |
| wr_data_o | output | 32 | Merged word to store |
| mask_o | output | 32 | Current bit mask |
| color_o | output | 32 | Current color register |
| wpb_o | output | 2 | Per-bank write-per-bit enables |

## Verification
Byte-lane blocking and bit-level masking can act on the same write beat, and they must combine lane by lane. The bench provokes this with a 0F0F0F0F mask on an enabled bank and a byte mask that blocks alternating lanes. Blocked lanes must return the old byte exactly, while open lanes must show the bitwise mix of new and old. A second case runs a write on the cycle right after a mask load, so the register update and its first use fall on adjacent edges. That write is judged against the newly loaded mask.

// File: rtl/wpb_mask_unit.sv
module wpb_mask_unit #(
  parameter int DATA_W = 32,
  parameter int BANKS  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               cmd_i,
  input  logic                     sf_i,
  input  logic [1:0]               addr_sel_i,
  input  logic [$clog2(BANKS)-1:0] bank_i,
  input  logic [DATA_W-1:0]        dq_i,
  input  logic [DATA_W/8-1:0]      bm_i,
  input  logic [DATA_W-1:0]        old_i,
  output logic                     wr_valid_o,
  output logic [DATA_W-1:0]        wr_data_o,
  output logic [DATA_W-1:0]        mask_o,
  output logic [DATA_W-1:0]        color_o,
  output logic [BANKS-1:0]         wpb_o
);
  localparam int LANES = DATA_W / 8;
  localparam logic [2:0] C_ACT = 3'd1, C_WR = 3'd2, C_MRS = 3'd3;

  logic [DATA_W-1:0] mask_q, color_q;
  logic [BANKS-1:0]  wpb_q;
  logic              spec_set, wpb_sel;
  logic [DATA_W-1:0] bit_mix;

  assign spec_set = (cmd_i == C_MRS) && sf_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      color_q <= '0;
      wpb_q   <= '0;
    end else begin
      if (spec_set && addr_sel_i[0]) mask_q  <= dq_i;
      if (spec_set && addr_sel_i[1]) color_q <= dq_i;
      if (cmd_i == C_ACT) wpb_q[bank_i] <= sf_i;
    end
  end

  assign wpb_sel = wpb_q[bank_i];
  assign bit_mix = wpb_sel ? ((mask_q & dq_i) | (~mask_q & old_i)) : dq_i;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign wr_data_o[b*8 +: 8] = bm_i[b] ? old_i[b*8 +: 8] : bit_mix[b*8 +: 8];
  end

  assign wr_valid_o = (cmd_i == C_WR);
  assign mask_o     = mask_q;
  assign color_o    = color_q;
  assign wpb_o      = wpb_q;
endmodule

// File: rtl/wpb_mask_unit_chk.sv
module wpb_mask_unit_chk #(
  parameter int DATA_W = 32,
  parameter int BANKS  = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               cmd_i,
  input logic                     sf_i,
  input logic [1:0]               addr_sel_i,
  input logic [$clog2(BANKS)-1:0] bank_i,
  input logic [DATA_W-1:0]        dq_i,
  input logic [DATA_W/8-1:0]      bm_i,
  input logic [DATA_W-1:0]        old_i,
  input logic                     wr_valid_o,
  input logic [DATA_W-1:0]        wr_data_o,
  input logic [DATA_W-1:0]        mask_o,
  input logic [DATA_W-1:0]        color_o,
  input logic [BANKS-1:0]         wpb_o
);
  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd3 && sf_i && addr_sel_i[0]) |=> mask_o == $past(dq_i));

  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_i == 3'd3 && sf_i && addr_sel_i[0]) |=> $stable(mask_o));

  a_r3_color_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd3 && sf_i && addr_sel_i[1]) |=> color_o == $past(dq_i));

  a_r4_both_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd3 && sf_i && addr_sel_i == 2'b11) |=> mask_o == color_o);

  a_r5_act_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1) |=> wpb_o[$past(bank_i)] == $past(sf_i));

  a_r7_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wpb_o[bank_i] && bm_i == '0) |-> wr_data_o == dq_i);

  for (genvar b = 0; b < DATA_W/8; b++) begin : g_lane_chk
    a_r8_lane_block: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && bm_i[b]) |-> wr_data_o[b*8 +: 8] == old_i[b*8 +: 8]);
  end
endmodule

bind wpb_mask_unit wpb_mask_unit_chk #(.DATA_W(DATA_W), .BANKS(BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .sf_i(sf_i), .addr_sel_i(addr_sel_i),
  .bank_i(bank_i), .dq_i(dq_i), .bm_i(bm_i), .old_i(old_i),
  .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .mask_o(mask_o),
  .color_o(color_o), .wpb_o(wpb_o));

// File: tb/wpb_mask_unit_tb_top.sv
module wpb_mask_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic        sf_i = 1'b0;
  logic [1:0]  addr_sel_i = 2'b00;
  logic        bank_i = 1'b0;
  logic [31:0] dq_i = '0, old_i = '0;
  logic [3:0]  bm_i = '0;
  logic        wr_valid_o;
  logic [31:0] wr_data_o, mask_o, color_o;
  logic [1:0]  wpb_o;

  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  wpb_mask_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .sf_i(sf_i), .addr_sel_i(addr_sel_i),
    .bank_i(bank_i), .dq_i(dq_i), .bm_i(bm_i), .old_i(old_i),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .mask_o(mask_o),
    .color_o(color_o), .wpb_o(wpb_o));

  typedef struct packed {
    logic [2:0]  cmd;
    logic        sf;
    logic [1:0]  sel;
    logic        bank;
    logic [3:0]  bm;
    logic [31:0] dq;
    logic [31:0] old;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 1'b0, 2'b00, 1'b0, 4'h0, 32'hA5A5A5A5, 32'hFFFF0000, 32'hA5A5A5A5, 4'd7}, // R7 reset state, enable off
    '{3'd3, 1'b1, 2'b01, 1'b0, 4'h0, 32'h0F0F0F0F, 32'h0,        32'h0,        4'd2}, // R2 mask load
    '{3'd2, 1'b0, 2'b00, 1'b0, 4'h0, 32'h12345678, 32'h0,        32'h12345678, 4'd7}, // R7 mask ignored
    '{3'd1, 1'b1, 2'b00, 1'b0, 4'h0, 32'h0,        32'h0,        32'h0,        4'd5}, // R5 enable bank 0
    '{3'd2, 1'b0, 2'b00, 1'b0, 4'h0, 32'hFFFFFFFF, 32'h0,        32'h0F0F0F0F, 4'd6}, // R6
    '{3'd2, 1'b0, 2'b00, 1'b1, 4'h0, 32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 4'd5}, // R5 bank 1 untouched
    '{3'd2, 1'b0, 2'b00, 1'b0, 4'h0, 32'h0,        32'hFFFFFFFF, 32'hF0F0F0F0, 4'd6}, // R6 old bits kept
    '{3'd2, 1'b0, 2'b00, 1'b0, 4'h5, 32'hAAAAAAAA, 32'h55555555, 32'h5A555A55, 4'd8}, // R8 with bit mask
    '{3'd2, 1'b0, 2'b00, 1'b1, 4'h8, 32'hAAAAAAAA, 32'h55555555, 32'h55AAAAAA, 4'd8}, // R8 without bit mask
    '{3'd3, 1'b0, 2'b01, 1'b0, 4'h0, 32'h0,        32'h0,        32'h0,        4'd2}, // R2 plain mode set
    '{3'd2, 1'b0, 2'b00, 1'b0, 4'h0, 32'hFFFFFFFF, 32'h0,        32'h0F0F0F0F, 4'd2}, // R2 mask unchanged
    '{3'd3, 1'b1, 2'b01, 1'b0, 4'h0, 32'hFF00FF00, 32'h0,        32'h0,        4'd9}, // R9 reload
    '{3'd2, 1'b0, 2'b00, 1'b0, 4'h0, 32'hFFFFFFFF, 32'h0,        32'hFF00FF00, 4'd9}, // R9 next-cycle use
    '{3'd1, 1'b0, 2'b00, 1'b0, 4'h0, 32'h0,        32'h0,        32'h0,        4'd5}, // R5 disable bank 0
    '{3'd2, 1'b0, 2'b00, 1'b0, 4'h0, 32'h12345678, 32'h0,        32'h12345678, 4'd5}  // R5 off again
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic s, input logic [1:0] a,
                       input logic b, input logic [31:0] d);
    @(negedge clk);
    cmd_i = c; sf_i = s; addr_sel_i = a; bank_i = b; dq_i = d; bm_i = '0; old_i = '0;
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 mask", mask_o, 32'hFFFFFFFF);
    check("R1 color", color_o, 32'h0);
    check("R1 wpb", {30'h0, wpb_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmd_i = VEC[i].cmd; sf_i = VEC[i].sf; addr_sel_i = VEC[i].sel;
      bank_i = VEC[i].bank; bm_i = VEC[i].bm; dq_i = VEC[i].dq; old_i = VEC[i].old;
      #1;
      // R10 valid only on write
      check("R10", {31'h0, wr_valid_o}, {31'h0, VEC[i].cmd == 3'd2});
      if (VEC[i].cmd == 3'd2)
        check($sformatf("R%0d row %0d", VEC[i].req, i), wr_data_o, VEC[i].exp);
    end

    // R3 color load, mask untouched
    drive(3'd3, 1'b1, 2'b10, 1'b0, 32'hCAFE1234);
    drive(3'd0, 1'b0, 2'b00, 1'b0, 32'h0);
    check("R3 color", color_o, 32'hCAFE1234);
    check("R3 mask kept", mask_o, 32'hFF00FF00);

    // R4 both registers from one value
    drive(3'd3, 1'b1, 2'b11, 1'b0, 32'h600DF00D);
    drive(3'd0, 1'b0, 2'b00, 1'b0, 32'h0);
    check("R4 mask", mask_o, 32'h600DF00D);
    check("R4 color", color_o, 32'h600DF00D);

    // R5 bank 1 enable, bank 0 stays off
    drive(3'd1, 1'b1, 2'b00, 1'b1, 32'h0);
    drive(3'd4, 1'b1, 2'b11, 1'b0, 32'hFFFFFFFF);
    #1;
    check("R5 wpb", {30'h0, wpb_o}, 32'h2);
    check("R10 code 4", {31'h0, wr_valid_o}, 32'h0);
    drive(3'd0, 1'b0, 2'b00, 1'b0, 32'h0);
    check("R10 code 4 no load", mask_o, 32'h600DF00D);

    // R1 reset again restores defaults
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 mask again", mask_o, 32'hFFFFFFFF);
    check("R1 wpb again", {30'h0, wpb_o}, 32'h0);
    check("R1 color again", color_o, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule